// File: doc/BRIEF.md
# Wide ALU with Byte-Shifted Operand

This block is the arithmetic and logic datapath for big-number work: it operates on 256-bit operands. It covers add, subtract, compare, immediate add and subtract, and the bitwise operations. A carry-in or borrow-in variant of add, subtract and compare lets software chain several wide words into one longer integer. Before the operation runs, the second operand can be shifted by a whole number of bytes toward either end, with zeros filling the vacated bytes. The block also performs a funnel right-shift across two operands and selects one of two operands according to a stored flag.

The datapath is combinational. The result and its write-enable follow the inputs in the same cycle. Flags live in a small bank of flag groups, two by default. Each group holds carry, top-bit, bottom-bit and zero flags. One group is named by each operation, and it is updated on the clock edge that ends a valid operation. The flags of the named group are always visible at the output, and the carry flag of that group feeds the chained variants. The register file and memory sit outside and use `res_we` to decide whether to store `result`.

Top module: `wide_alu`

## Requirements
- R1: Opcodes are ADD=0, ADDC=1, ADDI=2, SUB=3, SUBB=4, SUBI=5, CMP=6, CMPB=7, AND=8, OR=9, XOR=10, NOT=11, RSHI=12 and SEL=13. For addition and subtraction the result is the low 256 bits. The carry flag is bit 256 of the 257-bit unsigned sum or difference, so it is 1 on a borrow.
- R2: ADDC adds the carry flag of the selected group as a carry-in. SUBB and CMPB subtract that flag as a borrow-in. Plain ADD, SUB and CMP ignore it.
- R3: The second operand is shifted before use by `shift_bits` with its three low bits ignored, which gives a whole number of bytes. With `shift_left`=1 the shift is toward the MSB, and with 0 it is toward the LSB. Vacated bits are zero.
- R4: `flags_out` is {Z,L,M,C}, with C in bit 0, M in bit 1, L in bit 2 and Z in bit 3. M is result bit 255, L is result bit 0, and Z is 1 when all 256 result bits are zero.
- R5: CMP and CMPB update flags exactly as SUB and SUBB do, and they hold `res_we` low.
- R6: AND, OR and XOR combine A with the shifted B. NOT inverts the shifted B. All four write M, L and Z from the result and clear C.
- R7: RSHI returns the low 256 bits of {A,B} shifted right by `funnel_amt` (0 to 255), asserts `res_we`, and leaves every flag unchanged.
- R8: ADDI and SUBI use `imm` zero-extended in place of B, without the byte shift. They set all four flags as ADD and SUB do.
- R9: Flags reset to zero. A valid flag-writing operation updates only the group named by `flag_grp`, on the next rising clock edge. When `op_valid` is low, no flag changes and `res_we` is low.
- R10: SEL returns A when the flag of the selected group indexed by `sel_flag` (C=0, M=1, L=2, Z=3) is 1. Otherwise it returns B. It asserts `res_we` and changes no flag.
- R11: Opcodes 14 and 15 hold `res_we` low and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flag bank |
| op_valid | input | 1 | Qualifies the operation on the inputs this cycle |
| opcode | input | 4 | Operation code (see R1) |
| op_a | input | 256 | First operand |
| op_b | input | 256 | Second operand, subject to the byte shift |
| shift_left | input | 1 | Byte-shift direction: 1 toward MSB, 0 toward LSB |
| shift_bits | input | 8 | Byte-shift distance in bits; low three bits ignored |
| imm | input | 10 | Unsigned immediate for ADDI and SUBI |
| funnel_amt | input | 8 | Bit distance for RSHI |
| flag_grp | input | 1 | Flag group read and written by this operation |
| sel_flag | input | 2 | Flag index used by SEL |
| result | output | 256 | Operation result (the difference for compares) |
| res_we | output | 1 | Destination write strobe |
| flags_out | output | 4 | Current flags of the selected group {Z,L,M,C} |

## Verification
Several properties are checked on every clock, whatever the stimulus. An unselected or idle flag group keeps its value. A logical operation leaves carry clear. The stored zero and top-bit flags agree with the result the datapath showed one cycle earlier. A funnel shift or an undefined opcode leaves the visible flags untouched. The scenarios show what those invariants cannot: exact sums and differences at the 256-bit wrap, carry and borrow chaining through one group while the other group is left alone, the byte shift in both directions at its end stops with the low bits ignored, the funnel at its edge distances, and SEL choosing by each of the four flags.

// File: rtl/wide_alu_pkg.sv
package wide_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_ADDI = 4'd2,
        OP_SUB  = 4'd3,
        OP_SUBB = 4'd4,
        OP_SUBI = 4'd5,
        OP_CMP  = 4'd6,
        OP_CMPB = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11,
        OP_RSHI = 4'd12,
        OP_SEL  = 4'd13
    } alu_op_e;

    // Bit order matters: sel_flag indexes this word (C=0, M=1, L=2, Z=3).
    typedef struct packed {
        logic z;
        logic l;
        logic m;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/wide_alu_byte_shift.sv
module wide_alu_byte_shift #(
    parameter int W   = 256,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic           left,
    input  logic [SHW-1:0] amt_bits,
    output logic [W-1:0]   dout
);
    // Only whole bytes move: clear the sub-byte part of the distance.
    localparam logic [SHW-1:0] BYTE_MASK = ~SHW'(7);

    logic [SHW-1:0] amt_aligned;

    assign amt_aligned = amt_bits & BYTE_MASK;
    assign dout        = left ? (din << amt_aligned) : (din >> amt_aligned);

endmodule

// File: rtl/wide_alu_addsub.sv
module wide_alu_addsub
    import wide_alu_pkg::*;
#(
    parameter int W     = 256,
    parameter int IMM_W = 10
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b_sh,
    input  logic [IMM_W-1:0] imm,
    input  logic             cin,
    output logic [W-1:0]     sum,
    output logic             cout
);
    logic use_imm;
    logic do_sub;
    logic use_cin;

    always_comb begin
        use_imm = 1'b0;
        do_sub  = 1'b0;
        use_cin = 1'b0;
        case (op)
            OP_ADDC:         use_cin = 1'b1;
            OP_ADDI:         use_imm = 1'b1;
            OP_SUB, OP_CMP:  do_sub  = 1'b1;
            OP_SUBB, OP_CMPB: begin
                do_sub  = 1'b1;
                use_cin = 1'b1;
            end
            OP_SUBI: begin
                do_sub  = 1'b1;
                use_imm = 1'b1;
            end
            default: ;
        endcase
    end

    logic [W:0] opnd;
    logic [W:0] cin_ext;
    logic [W:0] full;

    assign opnd    = use_imm ? {{(W + 1 - IMM_W){1'b0}}, imm} : {1'b0, b_sh};
    assign cin_ext = {{W{1'b0}}, use_cin & cin};
    assign full    = do_sub ? ({1'b0, a} - opnd - cin_ext)
                            : ({1'b0, a} + opnd + cin_ext);
    assign sum     = full[W-1:0];
    assign cout    = full[W];

endmodule

// File: rtl/wide_alu_flag_bank.sv
module wide_alu_flag_bank
    import wide_alu_pkg::*;
#(
    parameter int NGRP  = 2,
    parameter int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [GRP_W-1:0] grp,
    input  alu_flags_t       wr_flags,
    output alu_flags_t       rd_flags
);
    alu_flags_t bank [NGRP];

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank[g] <= '0;
                end else if (we && (grp == GRP_W'(g))) begin
                    bank[g] <= wr_flags;
                end
            end

            // R9: a group not addressed by a write holds its value
            assert_grp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && (grp == GRP_W'(g))) |=> $stable(bank[g]));
        end
    endgenerate

    assign rd_flags = bank[grp];

endmodule

// File: rtl/wide_alu.sv
module wide_alu
    import wide_alu_pkg::*;
#(
    parameter int W     = 256,
    parameter int SHW   = $clog2(W),
    parameter int IMM_W = 10,
    parameter int NGRP  = 2,
    parameter int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       opcode,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic             shift_left,
    input  logic [SHW-1:0]   shift_bits,
    input  logic [IMM_W-1:0] imm,
    input  logic [SHW-1:0]   funnel_amt,
    input  logic [GRP_W-1:0] flag_grp,
    input  logic [1:0]       sel_flag,
    output logic [W-1:0]     result,
    output logic             res_we,
    output logic [3:0]       flags_out
);
    alu_op_e    op;
    logic [W-1:0] b_sh;
    logic [W-1:0] sum;
    logic         cout;
    alu_flags_t   cur_f;
    alu_flags_t   next_f;
    logic [3:0]   cur_bits;
    logic         upd_f;
    logic         wr_res;
    logic [W-1:0] res_c;

    assign op       = alu_op_e'(opcode);
    assign cur_bits = cur_f;

    wide_alu_byte_shift #(.W(W), .SHW(SHW)) u_bshift (
        .din      (op_b),
        .left     (shift_left),
        .amt_bits (shift_bits),
        .dout     (b_sh)
    );

    wide_alu_addsub #(.W(W), .IMM_W(IMM_W)) u_addsub (
        .op   (op),
        .a    (op_a),
        .b_sh (b_sh),
        .imm  (imm),
        .cin  (cur_f.c),
        .sum  (sum),
        .cout (cout)
    );

    always_comb begin
        res_c  = '0;
        wr_res = 1'b0;
        upd_f  = 1'b0;
        next_f = cur_f;
        unique case (op)
            OP_ADD, OP_ADDC, OP_ADDI, OP_SUB, OP_SUBB, OP_SUBI: begin
                res_c  = sum;
                wr_res = 1'b1;
                upd_f  = 1'b1;
            end
            OP_CMP, OP_CMPB: begin
                res_c = sum;
                upd_f = 1'b1;
            end
            OP_AND: begin
                res_c  = op_a & b_sh;
                wr_res = 1'b1;
                upd_f  = 1'b1;
            end
            OP_OR: begin
                res_c  = op_a | b_sh;
                wr_res = 1'b1;
                upd_f  = 1'b1;
            end
            OP_XOR: begin
                res_c  = op_a ^ b_sh;
                wr_res = 1'b1;
                upd_f  = 1'b1;
            end
            OP_NOT: begin
                res_c  = ~b_sh;
                wr_res = 1'b1;
                upd_f  = 1'b1;
            end
            OP_RSHI: begin
                res_c  = W'({op_a, op_b} >> funnel_amt);
                wr_res = 1'b1;
            end
            OP_SEL: begin
                res_c  = cur_bits[sel_flag] ? op_a : op_b;
                wr_res = 1'b1;
            end
            default: ;
        endcase
        if (upd_f) begin
            next_f.m = res_c[W-1];
            next_f.l = res_c[0];
            next_f.z = (res_c == '0);
            next_f.c = (op inside {OP_AND, OP_OR, OP_XOR, OP_NOT}) ? 1'b0 : cout;
        end
    end

    wide_alu_flag_bank #(.NGRP(NGRP), .GRP_W(GRP_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (op_valid && upd_f),
        .grp      (flag_grp),
        .wr_flags (next_f),
        .rd_flags (cur_f)
    );

    assign result    = res_c;
    assign res_we    = op_valid && wr_res;
    assign flags_out = cur_bits;

    // R6: after a logical operation the carry of that group reads clear
    assert_logic_clears_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode inside {4'd8, 4'd9, 4'd10, 4'd11})) ##1 $stable(flag_grp)
        |-> !flags_out[0]);

    // R4: stored Z and M agree with the result shown in the writing cycle
    assert_zero_msb_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode <= 4'd11)) ##1 $stable(flag_grp)
        |-> (flags_out[3] == ($past(result) == '0)) && (flags_out[1] == $past(result[W-1])));

    // R7: a funnel shift leaves the visible flags untouched
    assert_funnel_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode == 4'd12)) ##1 $stable(flag_grp) |-> $stable(flags_out));

    // R11: undefined codes write nothing
    assert_undef_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode >= 4'd14) |-> !res_we);

    assert_undef_keeps_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode >= 4'd14)) ##1 $stable(flag_grp) |-> $stable(flags_out));

endmodule

// File: tb/wide_alu_bench.sv
module wide_alu_bench;
    localparam int W      = 256;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           op_valid;
    logic [3:0]     opcode;
    logic [W-1:0]   op_a;
    logic [W-1:0]   op_b;
    logic           shift_left;
    logic [7:0]     shift_bits;
    logic [9:0]     imm;
    logic [7:0]     funnel_amt;
    logic [0:0]     flag_grp;
    logic [1:0]     sel_flag;
    logic [W-1:0]   result;
    logic           res_we;
    logic [3:0]     flags_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] mflags [2];
    logic [3:0] exp_q [$];
    string      req_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    wide_alu u_wide_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .opcode     (opcode),
        .op_a       (op_a),
        .op_b       (op_b),
        .shift_left (shift_left),
        .shift_bits (shift_bits),
        .imm        (imm),
        .funnel_amt (funnel_amt),
        .flag_grp   (flag_grp),
        .sel_flag   (sel_flag),
        .result     (result),
        .res_we     (res_we),
        .flags_out  (flags_out)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compare stored flags one edge after each operation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string      r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, "flags", W'(flags_out), W'(e));
            end
        end
    end

    // Driver: drive one operation, check the combinational outputs and
    // queue the expected flags of the addressed group.
    task automatic do_op(input string req, input logic [3:0] opc,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic left, input logic [7:0] sb,
                         input logic [9:0] iv, input logic [7:0] fa,
                         input logic g, input logic [1:0] sf,
                         input logic valid);
        logic [W-1:0] bs;
        logic [W:0]   full;
        logic [W-1:0] er;
        logic         ewe;
        logic         upd;
        logic         cin;
        logic         ec;
        logic [3:0]   nf;
        bs  = left ? (b << {sb[7:3], 3'b000}) : (b >> {sb[7:3], 3'b000});
        cin = mflags[g][0];
        er  = '0;
        ewe = 1'b0;
        upd = 1'b0;
        ec  = 1'b0;
        full = '0;
        case (opc)
            4'd0:  full = {1'b0, a} + {1'b0, bs};
            4'd1:  full = {1'b0, a} + {1'b0, bs} + (W + 1)'(cin);
            4'd2:  full = {1'b0, a} + (W + 1)'(iv);
            4'd3, 4'd6: full = {1'b0, a} - {1'b0, bs};
            4'd4, 4'd7: full = {1'b0, a} - {1'b0, bs} - (W + 1)'(cin);
            4'd5:  full = {1'b0, a} - (W + 1)'(iv);
            default: ;
        endcase
        case (opc)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: begin
                er = full[W-1:0]; ec = full[W]; ewe = 1'b1; upd = 1'b1;
            end
            4'd6, 4'd7: begin er = full[W-1:0]; ec = full[W]; upd = 1'b1; end
            4'd8:  begin er = a & bs; ewe = 1'b1; upd = 1'b1; end
            4'd9:  begin er = a | bs; ewe = 1'b1; upd = 1'b1; end
            4'd10: begin er = a ^ bs; ewe = 1'b1; upd = 1'b1; end
            4'd11: begin er = ~bs;    ewe = 1'b1; upd = 1'b1; end
            4'd12: begin
                logic [2*W-1:0] cat;
                cat = {a, b} >> fa;
                er  = cat[W-1:0];
                ewe = 1'b1;
            end
            4'd13: begin er = mflags[g][sf] ? a : b; ewe = 1'b1; end
            default: ;
        endcase
        nf = {(er == '0), er[0], er[W-1], ec};

        @(negedge clk);
        op_valid = valid; opcode = opc; op_a = a; op_b = b;
        shift_left = left; shift_bits = sb; imm = iv; funnel_amt = fa;
        flag_grp = g; sel_flag = sf;
        #1;
        check(req, "res_we", W'(res_we), W'(valid && ewe));
        if (valid && ewe) check(req, "result", result, er);
        if (valid && upd) mflags[g] = nf;
        exp_q.push_back(mflags[g]);
        req_q.push_back(req);
    endtask

    task automatic op(input string req, input logic [3:0] opc,
                      input logic [W-1:0] a, input logic [W-1:0] b, input logic g);
        do_op(req, opc, a, b, 1'b0, 8'd0, 10'd0, 8'd0, g, 2'd0, 1'b1);
    endtask

    initial begin
        logic [W-1:0] ones;
        logic [W-1:0] pat;
        ones = {W{1'b1}};
        pat  = {8{32'hC3A5_0F69}};
        mflags[0] = 4'h0;
        mflags[1] = 4'h0;
        rst_n = 1'b0; op_valid = 1'b0; opcode = 4'd0; op_a = '0; op_b = '0;
        shift_left = 1'b0; shift_bits = 8'd0; imm = 10'd0; funnel_amt = 8'd0;
        flag_grp = 1'b0; sel_flag = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R9", "reset flags g0", W'(flags_out), '0);
        flag_grp = 1'b1;
        #1;
        check("R9", "reset flags g1", W'(flags_out), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: wrap to zero with carry out (flags Z=1,C=1)
        op("R1", 4'd0, ones, 256'd1, 1'b0);
        // R2: carry-in from group 0
        op("R2", 4'd1, 256'd5, 256'd7, 1'b0);
        // R9: group 1 written, group 0 held
        op("R9", 4'd0, pat, pat, 1'b1);
        do_op("R9", 4'd0, ones, 256'd1, 1'b0, 8'd0, 10'd0, 8'd0, 1'b0, 2'd0, 1'b0);
        // R1: borrow on 0 - 1
        op("R1", 4'd3, 256'd0, 256'd1, 1'b0);
        // R2: borrow-in 10 - 3 - 1
        op("R2", 4'd4, 256'd10, 256'd3, 1'b0);
        // R2: plain ADD ignores carry flag
        op("R1", 4'd3, 256'd0, 256'd1, 1'b0);
        op("R2", 4'd0, 256'd4, 256'd4, 1'b0);
        // R5: compares
        op("R5", 4'd6, 256'd5, 256'd9, 1'b1);
        op("R5", 4'd7, 256'd9, 256'd8, 1'b1);
        op("R5", 4'd6, pat, pat, 1'b1);
        // R3: byte shifts, low bits ignored
        do_op("R3", 4'd0, 256'd0, pat, 1'b1, 8'd8, 10'd0, 8'd0, 1'b0, 2'd0, 1'b1);
        do_op("R3", 4'd0, 256'd0, pat, 1'b0, 8'd15, 10'd0, 8'd0, 1'b0, 2'd0, 1'b1);
        do_op("R3", 4'd0, 256'd0, 256'hFF, 1'b1, 8'd248, 10'd0, 8'd0, 1'b0, 2'd0, 1'b1);
        do_op("R3", 4'd11, 256'd0, ones, 1'b0, 8'd255, 10'd0, 8'd0, 1'b1, 2'd0, 1'b1);
        // R6: logic ops clear carry
        op("R1", 4'd0, ones, ones, 1'b0);
        op("R6", 4'd8, pat, ones, 1'b0);
        op("R1", 4'd0, ones, ones, 1'b0);
        op("R6", 4'd9, 256'd0, 256'd0, 1'b0);
        op("R6", 4'd10, pat, pat, 1'b1);
        do_op("R6", 4'd11, 256'd0, pat, 1'b1, 8'd16, 10'd0, 8'd0, 1'b0, 2'd0, 1'b1);
        // R7: funnel shift
        do_op("R7", 4'd12, pat, ones, 1'b0, 8'd0, 10'd0, 8'd0, 1'b0, 2'd0, 1'b1);
        do_op("R7", 4'd12, pat, 256'd0, 1'b0, 8'd0, 10'd0, 8'd4, 1'b0, 2'd0, 1'b1);
        do_op("R7", 4'd12, pat, 256'd0, 1'b0, 8'd0, 10'd0, 8'd255, 1'b1, 2'd0, 1'b1);
        // R8: immediates, shift ignored
        do_op("R8", 4'd2, 256'd1, pat, 1'b1, 8'd8, 10'd1023, 8'd0, 1'b0, 2'd0, 1'b1);
        do_op("R8", 4'd5, 256'd3, pat, 1'b0, 8'd8, 10'd4, 8'd0, 1'b1, 2'd0, 1'b1);
        // R10: select by each flag
        op("R1", 4'd3, 256'd0, 256'd1, 1'b0);
        for (int f = 0; f < 4; f++)
            do_op("R10", 4'd13, pat, ones, 1'b0, 8'd0, 10'd0, 8'd0, 1'b0, 2'(f), 1'b1);
        op("R1", 4'd0, 256'd2, 256'd0, 1'b0);
        for (int f = 0; f < 4; f++)
            do_op("R10", 4'd13, pat, ones, 1'b0, 8'd0, 10'd0, 8'd0, 1'b0, 2'(f), 1'b1);
        // R11: undefined codes
        op("R11", 4'd14, ones, ones, 1'b0);
        op("R11", 4'd15, 256'd0, 256'd0, 1'b1);

        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule